// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a byte-programmable timer with a counter and a reload register of equal width (16 bits by default). While its run input is high, it advances once for each cycle in which the timebase tick is asserted. With up/down mode off, it always counts upward. When the counter passes all ones, it wraps to the reload value. With up/down mode on, a direction input picks the way it counts. Counting up wraps as just described. Counting down stops at the reload value and jumps to all ones on the next tick.

Every wrap raises a sticky interrupt flag, which software clears through the write port. In up/down mode, every wrap also flips a toggle output. This gives a divided square wave, or an extra count bit, in either direction.

The run, mode and direction inputs are captured in a small state machine. Its states are OFF, FIXED_UP, UD_UP and UD_DOWN. Each cycle the machine moves to OFF when run is low. With run high, it moves to FIXED_UP when up/down mode is off, to UD_UP when the mode is on and direction is high, and to UD_DOWN when the mode is on and direction is low. Any state can reach any other state in one cycle.

Top module: `ud_reload_timer`

## Requirements
- R1: After reset the counter and reload register are 0, and both the interrupt flag and the toggle output are 0.
- R2: A write with address 0 or 1 replaces the low or high byte of the counter, and address 2 or 3 replaces the low or high byte of the reload register; the other byte is unchanged.
- R3: The counter changes only in cycles where both the active run state and tick are high; otherwise it holds.
- R4: With up/down mode off the counter increments on every counting tick, whatever the direction input.
- R5: With up/down mode on, direction 1 makes the counter increment and direction 0 makes it decrement.
- R6: A counting-up tick at all ones loads the reload value and sets the interrupt flag.
- R7: A counting-down tick while the counter equals the reload value loads all ones and sets the interrupt flag.
- R8: The toggle output flips on each wrap in up/down mode and never changes with up/down mode off.
- R9: The interrupt flag holds until a write to address 4 stores data bit 0 into it; a wrap in the same cycle leaves it set.
- R10: A counter byte write in the same cycle as a counting tick wins: the counter takes the written byte, with no increment, reload or flag set.
- R11: Run, mode and direction are registered, so a change applies from the next cycle's tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable, one counting step per high cycle |
| run | input | 1 | Run control |
| ud_en | input | 1 | Up/down mode enable |
| dir | input | 1 | Count direction in up/down mode (1 up, 0 down) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0/1 counter bytes, 2/3 reload bytes, 4 flag) |
| wr_data | input | 8 | Write data byte |
| count | output | 16 | Current counter value |
| irq | output | 1 | Sticky interrupt flag |
| tgl | output | 1 | Wrap toggle output |

## Verification
The bench builds the block with its default 16-bit counter of two byte lanes. Writing the counter to just below all ones, or just above the reload value, brings both wrap directions within a few ticks. A reload value of zero is also covered, so the down-count compare at the bottom of the range is exercised. A reference model predicts the count, flag and toggle for every cycle, which exposes direction changes, write-versus-tick collisions and set-versus-clear collisions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_FIXED_UP = 2'd1,
        ST_UD_UP    = 2'd2,
        ST_UD_DOWN  = 2'd3
    } tmr_state_e;
endpackage

// File: rtl/tmr_mode_fsm.sv
module tmr_mode_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ud_en,
    input  logic       dir,
    output tmr_state_e state_q,
    output logic       cnt_act,
    output logic       cnt_up,
    output logic       tgl_act
);
    tmr_state_e state_d;

    always_comb begin
        if (!run)
            state_d = ST_OFF;
        else if (!ud_en)
            state_d = ST_FIXED_UP;
        else if (dir)
            state_d = ST_UD_UP;
        else
            state_d = ST_UD_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        cnt_act = 1'b0;
        cnt_up  = 1'b1;
        tgl_act = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                cnt_act = 1'b0;
            end
            ST_FIXED_UP: begin
                cnt_act = 1'b1;
            end
            ST_UD_UP: begin
                cnt_act = 1'b1;
                tgl_act = 1'b1;
            end
            ST_UD_DOWN: begin
                cnt_act = 1'b1;
                cnt_up  = 1'b0;
                tgl_act = 1'b1;
            end
            default: begin
                cnt_act = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_act,
    input  logic              cnt_up,
    input  logic [LANES-1:0]  cnt_wr_lane,
    input  logic [LANES-1:0]  rel_wr_lane,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              wrap
);
    logic [CNT_W-1:0] cnt_merged;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_wr_any;
    logic             step;
    logic             at_top;
    logic             at_rel;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign cnt_merged[gi*BYTE_W +: BYTE_W] =
                cnt_wr_lane[gi] ? wr_data : count_q[gi*BYTE_W +: BYTE_W];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    reload_q[gi*BYTE_W +: BYTE_W] <= '0;
                else if (rel_wr_lane[gi])
                    reload_q[gi*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    endgenerate

    assign cnt_wr_any = |cnt_wr_lane;
    assign at_top     = (count_q == {CNT_W{1'b1}});
    assign at_rel     = (count_q == reload_q);
    assign step       = cnt_act & tick & ~cnt_wr_any;
    assign wrap       = step & (cnt_up ? at_top : at_rel);

    always_comb begin
        if (cnt_wr_any)
            cnt_d = cnt_merged;
        else if (wrap)
            cnt_d = cnt_up ? reload_q : {CNT_W{1'b1}};
        else if (step)
            cnt_d = cnt_up ? count_q + 1'b1 : count_q - 1'b1;
        else
            cnt_d = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else
            count_q <= cnt_d;
    end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic tgl_act,
    input  logic flag_wr,
    input  logic flag_val,
    output logic irq_q,
    output logic tgl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (wrap)
            irq_q <= 1'b1;
        else if (flag_wr)
            irq_q <= flag_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tgl_q <= 1'b0;
        else if (wrap && tgl_act)
            tgl_q <= ~tgl_q;
    end
endmodule

// File: rtl/ud_reload_timer.sv
module ud_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int LANES     = CNT_W / BYTE_W,
    localparam int FLAG_ADDR = 2 * LANES,
    localparam int ADDR_W    = $clog2(FLAG_ADDR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              ud_en,
    input  logic              dir,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              irq,
    output logic              tgl
);
    tmr_state_e       state_q;
    logic             cnt_act;
    logic             cnt_up;
    logic             tgl_act;
    logic [LANES-1:0] cnt_wr_lane;
    logic [LANES-1:0] rel_wr_lane;
    logic             cnt_wr_any;
    logic             flag_wr;
    logic [CNT_W-1:0] reload_q;
    logic             wrap;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_dec
            assign cnt_wr_lane[gi] = wr_en && (wr_addr == ADDR_W'(gi));
            assign rel_wr_lane[gi] = wr_en && (wr_addr == ADDR_W'(LANES + gi));
        end
    endgenerate

    assign cnt_wr_any = |cnt_wr_lane;
    assign flag_wr    = wr_en && (wr_addr == ADDR_W'(FLAG_ADDR));

    tmr_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .ud_en   (ud_en),
        .dir     (dir),
        .state_q (state_q),
        .cnt_act (cnt_act),
        .cnt_up  (cnt_up),
        .tgl_act (tgl_act)
    );

    tmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cnt_act     (cnt_act),
        .cnt_up      (cnt_up),
        .cnt_wr_lane (cnt_wr_lane),
        .rel_wr_lane (rel_wr_lane),
        .wr_data     (wr_data),
        .count_q     (count),
        .reload_q    (reload_q),
        .wrap        (wrap)
    );

    tmr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .tgl_act  (tgl_act),
        .flag_wr  (flag_wr),
        .flag_val (wr_data[0]),
        .irq_q    (irq),
        .tgl_q    (tgl)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input tmr_state_e       state_q,
    input logic             cnt_wr_any,
    input logic             flag_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_q,
    input logic             irq,
    input logic             tgl
);
    p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !cnt_wr_any) |=> $stable(count));

    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr_any) |=> $stable(count));

    p_up_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FIXED_UP || state_q == ST_UD_UP) && tick && !cnt_wr_any
         && count == {CNT_W{1'b1}}) |=> (count == $past(reload_q) && irq));

    p_down_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UD_DOWN && tick && !cnt_wr_any && count == reload_q)
        |=> (count == {CNT_W{1'b1}} && irq));

    p_fixed_no_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED_UP || state_q == ST_OFF) |=> $stable(tgl));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flag_wr) |=> irq);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_any && !irq && !flag_wr) |=> !irq);
endmodule

bind ud_reload_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .state_q    (state_q),
    .cnt_wr_any (cnt_wr_any),
    .flag_wr    (flag_wr),
    .count      (count),
    .reload_q   (reload_q),
    .irq        (irq),
    .tgl        (tgl)
);

// File: tb/tb_ud_reload_timer.sv
module tb_ud_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        run = 1'b0;
    logic        ud_en = 1'b0;
    logic        dir = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count;
    logic        irq;
    logic        tgl;

    always #(CLK_PERIOD/2) clk = ~clk;

    ud_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .ud_en(ud_en),
        .dir(dir), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .irq(irq), .tgl(tgl)
    );

    typedef struct {
        logic [15:0] cnt;
        logic        irq;
        logic        tgl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus settings and reference model
    bit          s_run = 0, s_ud = 0, s_dir = 0;
    bit          m_run = 0, m_ud = 0, m_dir = 0;
    logic [15:0] m_cnt = '0, m_rel = '0;
    bit          m_irq = 0, m_tgl = 0;

    task automatic compare(input logic [15:0] c, input logic i, input logic t,
                           input string tag);
        checks++;
        if (count !== c || irq !== i || tgl !== t) begin
            errors++;
            $display("FAIL %s: count=%h irq=%b tgl=%b expected count=%h irq=%b tgl=%b",
                     tag, count, irq, tgl, c, i, t);
        end
    endtask

    task automatic cyc(input bit t, input bit w, input logic [2:0] a,
                       input logic [7:0] d, input string tag);
        exp_t e;
        bit wrp;
        bit up;
        run = s_run; ud_en = s_ud; dir = s_dir;
        tick = t; wr_en = w; wr_addr = a; wr_data = d;
        wrp = 0;
        up = !m_ud || m_dir;
        if (w && a == 3'd0)
            m_cnt[7:0] = d;
        else if (w && a == 3'd1)
            m_cnt[15:8] = d;
        else if (m_run && t) begin
            if (up) begin
                if (m_cnt == 16'hFFFF) begin m_cnt = m_rel; wrp = 1; end
                else m_cnt = m_cnt + 16'd1;
            end else begin
                if (m_cnt == m_rel) begin m_cnt = 16'hFFFF; wrp = 1; end
                else m_cnt = m_cnt - 16'd1;
            end
        end
        if (w && a == 3'd2) m_rel[7:0] = d;
        if (w && a == 3'd3) m_rel[15:8] = d;
        if (wrp) m_irq = 1;
        else if (w && a == 3'd4) m_irq = d[0];
        if (wrp && m_ud) m_tgl = !m_tgl;
        m_run = s_run; m_ud = s_ud; m_dir = s_dir;
        e.cnt = m_cnt; e.irq = m_irq; e.tgl = m_tgl; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input bit t, input string tag);
        cyc(t, 0, 3'd0, 8'h00, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cyc(0, 1, a, d, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e.cnt, e.irq, e.tgl, e.tag);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare(16'h0000, 1'b0, 1'b0, "R1 reset state");

        // R2 byte writes
        wr(3'd0, 8'hFD, "R2 count low");
        wr(3'd1, 8'hFF, "R2 count high");
        wr(3'd2, 8'h34, "R2 reload low");
        wr(3'd3, 8'h12, "R2 reload high");

        // R3 run low holds despite tick
        idle(1, "R3 stopped");
        idle(1, "R3 stopped");
        s_run = 1;
        idle(1, "R11 run registered, no count yet");
        idle(0, "R3 no tick holds");

        // R4 fixed up, direction ignored
        s_dir = 0;
        idle(1, "R4 up with dir 0");
        idle(1, "R4 up to top");
        idle(1, "R6 up wrap to reload, R8 no toggle");
        idle(0, "R6 flag stays");

        // R9 clear and collision
        wr(3'd4, 8'h00, "R9 clear flag");
        idle(0, "R9 flag stays clear");
        wr(3'd0, 8'hFF, "R2 count low");
        wr(3'd1, 8'hFF, "R2 count high");
        cyc(1, 1, 3'd4, 8'h00, "R9 wrap beats clear");
        wr(3'd4, 8'h00, "R9 clear flag");

        // R10 write wins over tick at top
        wr(3'd1, 8'hFF, "R2 count high");
        wr(3'd0, 8'hFF, "R2 count low");
        cyc(1, 1, 3'd0, 8'h00, "R10 write beats wrap");
        idle(0, "R10 no flag");

        // R5 / R7 down counting
        s_ud = 1; s_dir = 0;
        wr(3'd0, 8'h36, "R2 count low");
        wr(3'd1, 8'h12, "R2 count high");
        idle(1, "R5 down");
        idle(1, "R5 down to reload");
        idle(1, "R7 down reload all ones, R8 toggle");
        idle(1, "R5 down from top");

        // R11 direction change applies next cycle
        s_dir = 1;
        idle(1, "R11 old direction still down");
        idle(1, "R5 up");
        idle(1, "R5 up to top");
        wr(3'd4, 8'h00, "R9 clear flag");
        idle(1, "R6 up wrap, R8 toggle back");

        // R11 run low applies next cycle
        s_run = 0;
        idle(1, "R11 one more count");
        idle(1, "R3 stopped holds");

        // R7 down with reload zero
        s_run = 1; s_dir = 0;
        wr(3'd2, 8'h00, "R2 reload low");
        wr(3'd3, 8'h00, "R2 reload high");
        wr(3'd0, 8'h01, "R2 count low");
        wr(3'd1, 8'h00, "R2 count high");
        wr(3'd4, 8'h00, "R9 clear flag");
        idle(1, "R5 down to zero");
        idle(1, "R7 zero reload wraps to all ones");
        idle(0, "R7 hold");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule